// File: doc/BRIEF.md
# Single-Wire Debug Handshake Responder

This block is the target end of a one-wire, open-drain debug link. It watches the shared pin through a two-stage synchroniser and measures how long each low phase lasts. When the host holds the pin low long enough to count as a synchronisation request and then lets it go, the block waits a short gap. It then pulls the pin low for a fixed sync response and finishes with a one-cycle active-high speedup drive before releasing the pin.

The block also tracks whether a debug command is pending. When the execution logic reports that the command has finished, the block can tell the host with a short low acknowledge pulse, again closed by a one-cycle speedup drive. The acknowledge is switched on and off by two dedicated handshake opcodes and is off after reset. A sync request that arrives while a command is pending aborts that command: a one-cycle abort strobe is raised and no acknowledge follows. Nothing stops an acknowledge from overlapping a host sync pulse; when the two meet, the sync request wins.

The controller has six states. `HS_IDLE` goes to `HS_SYNC_GAP` on a detected sync and to `HS_ACK_LOW` on an acknowledge request. `HS_ACK_LOW` goes to `HS_ACK_SPD` after `ACK_LOW` cycles. `HS_ACK_SPD` returns to `HS_IDLE`. Both acknowledge states go to `HS_SYNC_GAP` on a detected sync. `HS_SYNC_GAP` goes to `HS_RESP_LOW` after `RESP_GAP` cycles, `HS_RESP_LOW` goes to `HS_RESP_SPD` after `RESP_LOW` cycles, and `HS_RESP_SPD` returns to `HS_IDLE`.

Top module: `sw_dbg_handshake`

## Requirements
- R1: After reset, `drive_low_o`, `drive_high_o` and `abort_o` are 0 and the handshake is disabled, so a finished command gives no acknowledge.
- R2: A command strobe with opcode 8'hD5 enables the handshake and one with opcode 8'hD6 disables it. These two opcodes never make a command pending. Any other opcode makes a command pending.
- R3: When the handshake is enabled, a command is pending and the controller is idle, a `done_i` strobe starts an acknowledge on the next cycle. The acknowledge is `drive_low_o` for 16 cycles, then `drive_high_o` for exactly one cycle, then both released.
- R4: While the handshake is disabled, `done_i` produces no drive on the pin.
- R5: A `done_i` strobe with no pending command produces no acknowledge, and `done_i` clears the pending command.
- R6: A sync request is detected when the synchronised pin rises after at least 128 consecutive low samples. A low phase of 127 samples produces no response.
- R7: After a detected sync, the pin stays released for 4 cycles, then `drive_low_o` is high for 128 cycles, then `drive_high_o` is high for one cycle. The first drive-low cycle is seen 7 cycles after the first high pin sample.
- R8: A sync detected while a command is pending raises `abort_o` for exactly one cycle and drops the command, so a later `done_i` gives no acknowledge. A sync with no command pending gives no abort.
- R9: The low-pulse counter saturates and never exceeds 128, so a host low pulse of several hundred cycles is still a sync request.
- R10: `drive_low_o` and `drive_high_o` are never high in the same cycle.
- R11: The pin is ignored during the sync response, so the block's own 128-cycle low drive does not start a second response.
- R12: If `done_i` arrives in the same cycle that a sync is detected, the sync wins: `abort_o` is raised and no acknowledge is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Raw level read back from the shared debug pin |
| cmd_valid_i | input | 1 | One-cycle strobe: a command has been decoded |
| cmd_op_i | input | OP_W | Opcode of the decoded command |
| done_i | input | 1 | One-cycle strobe: the pending command has finished |
| drive_low_o | output | 1 | Enable for the open-drain pull-down on the pin |
| drive_high_o | output | 1 | Enable for the brief active-high speedup drive |
| abort_o | output | 1 | One-cycle strobe: the pending command was aborted by a sync |

## Verification
The bench targets the threshold edge with a 127-sample pulse and a 128-sample pulse. A detector that is off by one would either answer the short pulse or ignore the minimum valid one. A 400-cycle pulse tests saturation: a counter that wraps would see a short count on release and stay silent. The bench also checks the response against its own pin readback. A design that does not blank its input would treat its own 128-cycle low drive as a second sync and answer it again. Last, `done_i` is placed in exactly the cycle that a sync is detected, and again after an abort. A design that gave priority to the acknowledge, or kept the aborted command pending, would drive a 16-cycle low pulse that the reference model does not expect.

// File: rtl/dbg_hs_pkg.sv
package dbg_hs_pkg;

    typedef enum logic [2:0] {
        HS_IDLE     = 3'd0,
        HS_ACK_LOW  = 3'd1,
        HS_ACK_SPD  = 3'd2,
        HS_SYNC_GAP = 3'd3,
        HS_RESP_LOW = 3'd4,
        HS_RESP_SPD = 3'd5
    } hs_state_e;

    function automatic logic in_response(input hs_state_e st);
        return (st == HS_SYNC_GAP) || (st == HS_RESP_LOW) || (st == HS_RESP_SPD);
    endfunction

endpackage

// File: rtl/dbg_pin_sync.sv
module dbg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_s
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= 1'b1;
                end else if (g == 0) begin
                    chain_q[g] <= pin_raw;
                end else begin
                    chain_q[g] <= chain_q[(g > 0) ? g - 1 : 0];
                end
            end
        end
    endgenerate

    assign pin_s = chain_q[STAGES-1];
endmodule

// File: rtl/dbg_low_meter.sv
module dbg_low_meter #(
    parameter int SYNC_MIN = 128,
    localparam int CNT_W = $clog2(SYNC_MIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_s,
    input  logic             blank,
    output logic             sync_hit,
    output logic [CNT_W-1:0] low_run
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(SYNC_MIN);

    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (blank || pin_s) begin
            run_q <= '0;
        end else if (run_q != CAP) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign sync_hit = !blank && pin_s && (run_q == CAP);
    assign low_run  = run_q;
endmodule

// File: rtl/dbg_cmd_track.sv
module dbg_cmd_track #(
    parameter int              OP_W   = 8,
    parameter logic [OP_W-1:0] OP_ON  = 8'hD5,
    parameter logic [OP_W-1:0] OP_OFF = 8'hD6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic            done,
    input  logic            sync_hit,
    output logic            ack_req,
    output logic            abort
);
    logic pend_q;
    logic en_q;
    logic abort_q;
    logic is_hs_op;

    assign is_hs_op = (cmd_op == OP_ON) || (cmd_op == OP_OFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            en_q    <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            abort_q <= sync_hit && pend_q;
            if (cmd_valid && cmd_op == OP_ON) begin
                en_q <= 1'b1;
            end else if (cmd_valid && cmd_op == OP_OFF) begin
                en_q <= 1'b0;
            end
            if (sync_hit) begin
                pend_q <= 1'b0;
            end else if (cmd_valid && !is_hs_op) begin
                pend_q <= 1'b1;
            end else if (done) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign ack_req = done && pend_q && en_q && !sync_hit;
    assign abort   = abort_q;
endmodule

// File: rtl/dbg_hs_fsm.sv
module dbg_hs_fsm
    import dbg_hs_pkg::*;
#(
    parameter int ACK_LOW  = 16,
    parameter int RESP_GAP = 4,
    parameter int RESP_LOW = 128,
    localparam int MAX_A   = (ACK_LOW > RESP_GAP) ? ACK_LOW : RESP_GAP,
    localparam int MAX_T   = (MAX_A > RESP_LOW) ? MAX_A : RESP_LOW,
    localparam int TMR_W   = $clog2(MAX_T + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_hit,
    input  logic ack_req,
    output logic drive_low,
    output logic drive_high,
    output logic blank
);
    localparam logic [TMR_W-1:0] ACK_END  = TMR_W'(ACK_LOW - 1);
    localparam logic [TMR_W-1:0] GAP_END  = TMR_W'(RESP_GAP - 1);
    localparam logic [TMR_W-1:0] RESP_END = TMR_W'(RESP_LOW - 1);

    hs_state_e        state_q, state_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q + 1'b1;
        unique case (state_q)
            HS_IDLE: begin
                tmr_d = '0;
                if (sync_hit)     state_d = HS_SYNC_GAP;
                else if (ack_req) state_d = HS_ACK_LOW;
            end
            HS_ACK_LOW: begin
                if (sync_hit) begin
                    state_d = HS_SYNC_GAP;
                    tmr_d   = '0;
                end else if (tmr_q == ACK_END) begin
                    state_d = HS_ACK_SPD;
                    tmr_d   = '0;
                end
            end
            HS_ACK_SPD: begin
                tmr_d   = '0;
                state_d = sync_hit ? HS_SYNC_GAP : HS_IDLE;
            end
            HS_SYNC_GAP: begin
                if (tmr_q == GAP_END) begin
                    state_d = HS_RESP_LOW;
                    tmr_d   = '0;
                end
            end
            HS_RESP_LOW: begin
                if (tmr_q == RESP_END) begin
                    state_d = HS_RESP_SPD;
                    tmr_d   = '0;
                end
            end
            HS_RESP_SPD: begin
                state_d = HS_IDLE;
                tmr_d   = '0;
            end
            default: begin
                state_d = HS_IDLE;
                tmr_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    always_comb begin
        drive_low  = 1'b0;
        drive_high = 1'b0;
        unique case (state_q)
            HS_ACK_LOW, HS_RESP_LOW: drive_low  = 1'b1;
            HS_ACK_SPD, HS_RESP_SPD: drive_high = 1'b1;
            default: ;
        endcase
        blank = in_response(state_q);
    end
endmodule

// File: rtl/sw_dbg_handshake.sv
module sw_dbg_handshake #(
    parameter int              OP_W       = 8,
    parameter logic [OP_W-1:0] OP_ACK_ON  = 8'hD5,
    parameter logic [OP_W-1:0] OP_ACK_OFF = 8'hD6,
    parameter int              SYNC_MIN   = 128,
    parameter int              ACK_LOW    = 16,
    parameter int              RESP_GAP   = 4,
    parameter int              RESP_LOW   = 128,
    parameter int              SYNC_STG   = 2,
    localparam int             CNT_W      = $clog2(SYNC_MIN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_i,
    input  logic            cmd_valid_i,
    input  logic [OP_W-1:0] cmd_op_i,
    input  logic            done_i,
    output logic            drive_low_o,
    output logic            drive_high_o,
    output logic            abort_o
);
    logic             pin_s;
    logic             blank;
    logic             sync_hit;
    logic             ack_req;
    logic [CNT_W-1:0] low_run;

    dbg_pin_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (pin_i),
        .pin_s   (pin_s)
    );

    dbg_low_meter #(.SYNC_MIN(SYNC_MIN)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_s),
        .blank    (blank),
        .sync_hit (sync_hit),
        .low_run  (low_run)
    );

    dbg_cmd_track #(.OP_W(OP_W), .OP_ON(OP_ACK_ON), .OP_OFF(OP_ACK_OFF)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid_i),
        .cmd_op    (cmd_op_i),
        .done      (done_i),
        .sync_hit  (sync_hit),
        .ack_req   (ack_req),
        .abort     (abort_o)
    );

    dbg_hs_fsm #(.ACK_LOW(ACK_LOW), .RESP_GAP(RESP_GAP), .RESP_LOW(RESP_LOW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_hit   (sync_hit),
        .ack_req    (ack_req),
        .drive_low  (drive_low_o),
        .drive_high (drive_high_o),
        .blank      (blank)
    );
endmodule

// File: rtl/dbg_hs_checker.sv
module dbg_hs_checker #(
    parameter int SYNC_MIN = 128,
    parameter int CNT_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             drive_low,
    input logic             drive_high,
    input logic             abort,
    input logic [CNT_W-1:0] low_run
);
    AST_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_low && drive_high)); // R10

    AST_SPD_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_high) |-> $past(drive_low)); // R3

    AST_SPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        drive_high |=> !drive_high); // R7

    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort); // R8

    AST_ABORT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (!drive_low && !drive_high)); // R8

    AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        32'(low_run) <= SYNC_MIN); // R9
endmodule

bind sw_dbg_handshake dbg_hs_checker #(.SYNC_MIN(SYNC_MIN), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .drive_low  (drive_low_o),
    .drive_high (drive_high_o),
    .abort      (abort_o),
    .low_run    (low_run)
);

// File: tb/sw_dbg_handshake_tb.sv
`timescale 1ns/1ps
module sw_dbg_handshake_tb;
    localparam int SYNC_MIN = 128;
    localparam int ACK_LOW  = 16;
    localparam int RESP_GAP = 4;
    localparam int RESP_LOW = 128;
    localparam logic [7:0] OP_ON  = 8'hD5;
    localparam logic [7:0] OP_OFF = 8'hD6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_low = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_op = 8'h00;
    logic       done = 1'b0;
    logic       drive_low_o, drive_high_o, abort_o;
    logic       pin_w;

    int checks = 0;
    int errors = 0;
    int low_cyc = 0, high_cyc = 0, abort_cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign pin_w = (host_low || drive_low_o) ? 1'b0 : 1'b1;

    sw_dbg_handshake u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (pin_w),
        .cmd_valid_i  (cmd_valid),
        .cmd_op_i     (cmd_op),
        .done_i       (done),
        .drive_low_o  (drive_low_o),
        .drive_high_o (drive_high_o),
        .abort_o      (abort_o)
    );

    // Reference model: pin history, low run length, pending/enable flags
    // and a queue of the output kinds expected in upcoming cycles.
    // Kinds: 0 idle, 1 ack low, 2 ack high, 3 resp gap, 4 resp low, 5 resp high.
    int  q[$];
    int  cur = 0;
    int  run = 0;
    bit  p1 = 1, p2 = 1, pend = 0, en = 0, ab = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); cur = 0; run = 0; p1 = 1; p2 = 1; pend = 0; en = 0; ab = 0;
        end else begin
            bit pin_now, in_resp, hit, ackgo;
            pin_now = (host_low || cur == 1 || cur == 4) ? 1'b0 : 1'b1;
            in_resp = (cur >= 3);
            hit     = !in_resp && p2 && (run >= SYNC_MIN);
            ackgo   = !hit && done && pend && en && (cur == 0);
            ab      = hit && pend;
            if (hit) pend = 0;
            else if (cmd_valid && cmd_op != OP_ON && cmd_op != OP_OFF) pend = 1;
            else if (done) pend = 0;
            if (cmd_valid && cmd_op == OP_ON) en = 1;
            else if (cmd_valid && cmd_op == OP_OFF) en = 0;
            if (in_resp || p2) run = 0;
            else if (run < SYNC_MIN) run = run + 1;
            p2 = p1;
            p1 = pin_now;
            if (hit) begin
                q.delete();
                for (int i = 0; i < RESP_GAP; i++) q.push_back(3);
                for (int i = 0; i < RESP_LOW; i++) q.push_back(4);
                q.push_back(5);
            end else if (ackgo) begin
                for (int i = 0; i < ACK_LOW; i++) q.push_back(1);
                q.push_back(2);
            end
            cur = (q.size() > 0) ? q.pop_front() : 0;
        end
    end

    // Per-cycle comparison against the model, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit el, eh;
            el = (cur == 1 || cur == 4);
            eh = (cur == 2 || cur == 5);
            checks++;
            if (drive_low_o !== el || drive_high_o !== eh || abort_o !== ab) begin
                errors++;
                $display("FAIL %s cycle compare: low/high/abort act=%b%b%b exp=%b%b%b",
                         (cur == 1 || cur == 2) ? "R3" : (cur >= 3) ? "R7" : (ab ? "R8" : "R10"),
                         drive_low_o, drive_high_o, abort_o, el, eh, ab);
            end
            if (drive_low_o)  low_cyc++;
            if (drive_high_o) high_cyc++;
            if (abort_o)      abort_cyc++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        low_cyc = 0; high_cyc = 0; abort_cyc = 0;
    endtask

    task automatic check(input string req, input int act, input int exp_v, input string what);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    task automatic send_cmd(input logic [7:0] op);
        cmd_op = op; cmd_valid = 1'b1;
        cyc(1);
        cmd_valid = 1'b0;
        cyc(1);
    endtask

    task automatic pulse_done();
        done = 1'b1;
        cyc(1);
        done = 1'b0;
    endtask

    task automatic host_pulse(input int len);
        host_low = 1'b1;
        cyc(len);
        host_low = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int gap_n;
        cyc(4);
        check("R1", {31'd0, drive_low_o} + {31'd0, drive_high_o} + {31'd0, abort_o}, 0, "outputs in reset");
        rst_n = 1'b1;
        cyc(3);
        check("R1", {31'd0, drive_low_o} + {31'd0, drive_high_o}, 0, "outputs after reset");

        // R1/R4: handshake disabled out of reset
        clr(); send_cmd(8'h30); pulse_done(); cyc(30);
        check("R1", low_cyc, 0, "ack while disabled after reset");

        // R2/R3: enable, then a command completes
        send_cmd(OP_ON); send_cmd(8'h31); clr(); pulse_done(); cyc(30);
        check("R3", low_cyc, ACK_LOW, "ack low cycles");
        check("R3", high_cyc, 1, "ack speedup cycles");

        // R5: done with nothing pending
        clr(); pulse_done(); cyc(30);
        check("R5", low_cyc, 0, "ack without pending command");

        // R2: handshake opcode does not make a command pending
        clr(); send_cmd(OP_ON); pulse_done(); cyc(30);
        check("R2", low_cyc, 0, "enable opcode treated as command");

        // R4: disable
        send_cmd(OP_OFF); send_cmd(8'h32); clr(); pulse_done(); cyc(30);
        check("R4", low_cyc, 0, "ack while disabled");
        send_cmd(OP_ON);

        // R6: 127 samples too short
        clr(); host_pulse(SYNC_MIN - 1); cyc(200);
        check("R6", low_cyc, 0, "response to short pulse");

        // R6/R7/R11: minimum sync and response timing
        clr(); host_low = 1'b1; cyc(SYNC_MIN); host_low = 1'b0;
        gap_n = 0;
        while (!drive_low_o && gap_n < 50) begin cyc(1); gap_n++; end
        check("R7", gap_n, 3 + RESP_GAP, "cycles from release to response");
        cyc(400);
        check("R6", high_cyc, 1, "speedup after minimum sync");
        check("R11", low_cyc, RESP_LOW, "response low cycles, no retrigger");
        check("R8", abort_cyc, 0, "abort with nothing pending");

        // R8: sync aborts pending command
        send_cmd(8'h33); clr(); host_pulse(200); cyc(200);
        check("R8", abort_cyc, 1, "abort strobe count");
        clr(); pulse_done(); cyc(30);
        check("R8", low_cyc, 0, "ack after aborted command");

        // R9: very long pulse still a sync
        clr(); host_pulse(400); cyc(200);
        check("R9", low_cyc, RESP_LOW, "response after long pulse");

        // R12: done in the same cycle as sync detection
        send_cmd(8'h34); clr(); host_low = 1'b1; cyc(150); host_low = 1'b0;
        cyc(2); pulse_done(); cyc(200);
        check("R12", abort_cyc, 1, "abort when done meets sync");
        check("R12", low_cyc, RESP_LOW, "no ack when done meets sync");

        // R3 again after all of that
        send_cmd(8'h35); clr(); pulse_done(); cyc(30);
        check("R3", low_cyc, ACK_LOW, "ack after sync traffic");
        check("R10", high_cyc, 1, "single speedup");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule